// File: doc/BRIEF.md
# Background LMS Calibration Engine for a Redundant-Stage Converter

This block sits behind a fast pipelined converter whose stages each resolve a 1.5-bit code (minus one, zero or plus one). It rebuilds the output word as a signed weighted sum of those stage codes, with one adaptive weight per stage. Because the stages are redundant, the weights absorb the overlap between neighbouring stages, and they also absorb the gain errors of the analog stages.

A slow, accurate reference converter samples the same input once in every `DECIM` fast samples. The engine marks those fast samples, keeps each marked sample's stage codes and full-precision sum, and waits for the matching reference strobe. When the strobe arrives it forms the error between the reference word and the held sum. It then moves every weight by a least-mean-square step, the error times the stage code scaled down by a programmable power of two. The weights saturate rather than wrap, and a freeze input holds them while still letting the strobes pass through.

Top module: `lms_bg_cal`

## Requirements
- R1: A fast sample presented with `samp_vld` high produces `y_vld` high and its corrected word on `y_out` one clock later. In a cycle after `samp_vld` was low, `y_vld` is low and `y_out` keeps its value. Both outputs are 0 after reset.
- R2: After reset, the weight of stage k (stage 0 being the most significant) is 2^(FRAC+NSTG-1-k). Weights carry FRAC fractional bits. `y_out` is the floor of (sum of code_k times weight_k) / 2^FRAC.
- R3: Stage k's code sits at `stage_codes[2k+1:2k]`. The value 2'b01 means +1, 2'b11 means -1, and both 2'b00 and the unused 2'b10 mean 0.
- R4: The first sample after reset is a marked sample, and so is every DECIM-th sample after it. A marked sample's codes and full-precision sum are held for calibration. Unmarked samples are not held.
- R5: A `ref_vld` strobe that finds a held sample with `freeze` low computes e = `ref_word`*2^FRAC - held_sum. It then adds (e*code_k) >>> `mu_sh` (arithmetic shift) to every weight k. The new weights apply from the next cycle, and the held sample is consumed. A stage whose held code is 0 keeps its weight.
- R6: A `ref_vld` strobe that finds no held sample changes no weight, including a second strobe after the first has consumed the held sample.
- R7: While `freeze` is high no weight changes. A strobe in that state still consumes the held sample.
- R8: A weight update beyond the signed WW-bit range is clamped to 2^(WW-1)-1 or to -2^(WW-1).
- R9: A newer marked sample replaces a held sample that has not yet been consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_vld | input | 1 | Fast sample present this cycle |
| stage_codes | input | 2*NSTG | Per-stage 1.5-bit codes, stage 0 in the low bits |
| ref_vld | input | 1 | Reference word strobe |
| ref_word | input | YW | Signed reference result, in output LSBs |
| mu_sh | input | MUW | Step-size right shift |
| freeze | input | 1 | Hold all weights |
| y_vld | output | 1 | Corrected word valid |
| y_out | output | YW | Signed corrected word |

## Verification
The bench steers the marked-sample phase on purpose. It sends a marked sample followed by a different unmarked one before the strobe, so a design that held the wrong sample would adapt in the wrong direction. It also sends a full decimation period without a strobe, so a design that kept the older marked sample instead of the newer one would fail. A strobe with nothing held and a repeated strobe are both sent, and weights that drift there show up in later probe words. Large errors with a zero shift drive a weight past both ends of its range, where a wrapping adder would flip the sign of the probe output. A frozen strobe followed by an unfrozen one would expose a design that leaves the held sample pending under freeze.

// File: rtl/lms_cal_pkg.sv
package lms_cal_pkg;

    typedef enum logic [1:0] {
        CODE_ZERO = 2'b00,
        CODE_POS  = 2'b01,
        CODE_RSV  = 2'b10,
        CODE_NEG  = 2'b11
    } stage_code_e;

    typedef logic signed [1:0] trit_t;

    // Map a raw 1.5-bit stage code to its signed digit.
    function automatic trit_t code_to_trit(input logic [1:0] raw);
        case (stage_code_e'(raw))
            CODE_POS: return 2'sd1;
            CODE_NEG: return -2'sd1;
            default:  return 2'sd0;
        endcase
    endfunction

    // Binary position of the ideal weight of stage k.
    function automatic int ideal_pos(input int frac, input int nstg, input int k);
        return frac + nstg - 1 - k;
    endfunction

endpackage

// File: rtl/lms_sum.sv
module lms_sum
    import lms_cal_pkg::*;
#(
    parameter int NSTG = 6,
    parameter int WW   = 16,
    parameter int AW   = 20
) (
    input  logic [2*NSTG-1:0]   codes,
    input  logic signed [WW-1:0] w [NSTG],
    output logic signed [AW-1:0] acc
);

    always_comb begin
        trit_t t;
        acc = '0;
        for (int k = 0; k < NSTG; k++) begin
            t = code_to_trit(codes[2*k +: 2]);
            if (t == 2'sd1) begin
                acc = acc + AW'(w[k]);
            end else if (t == -2'sd1) begin
                acc = acc - AW'(w[k]);
            end
        end
    end

endmodule

// File: rtl/lms_tagger.sv
module lms_tagger #(
    parameter int NSTG  = 6,
    parameter int AW    = 20,
    parameter int DECIM = 32,
    localparam int CW   = (DECIM > 1) ? $clog2(DECIM) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 samp_vld,
    input  logic [2*NSTG-1:0]    codes,
    input  logic signed [AW-1:0] acc,
    input  logic                 ref_vld,
    output logic [2*NSTG-1:0]    held_codes,
    output logic signed [AW-1:0] held_acc,
    output logic                 pend
);

    localparam logic [CW-1:0] LAST = CW'(DECIM - 1);

    logic [CW-1:0] phase;
    logic          mark;

    assign mark = samp_vld && (phase == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (samp_vld) begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_codes <= '0;
            held_acc   <= '0;
            pend       <= 1'b0;
        end else begin
            if (mark) begin
                held_codes <= codes;
                held_acc   <= acc;
                pend       <= 1'b1;
            end else if (ref_vld) begin
                pend       <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/lms_weights.sv
module lms_weights
    import lms_cal_pkg::*;
#(
    parameter int NSTG = 6,
    parameter int WW   = 16,
    parameter int FRAC = 6,
    parameter int EW   = 21,
    parameter int MUW  = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 upd,
    input  logic signed [EW-1:0] err,
    input  logic [MUW-1:0]       mu_sh,
    input  logic [2*NSTG-1:0]    held_codes,
    output logic signed [WW-1:0] w [NSTG]
);

    localparam int DW = EW + 1;
    localparam int SW = DW + 1;
    localparam logic signed [WW-1:0] WMAX = {1'b0, {(WW-1){1'b1}}};
    localparam logic signed [WW-1:0] WMIN = {1'b1, {(WW-1){1'b0}}};

    for (genvar k = 0; k < NSTG; k++) begin : g_stage
        localparam logic signed [WW-1:0] IDEAL =
            WW'(64'sd1 << ideal_pos(FRAC, NSTG, k));

        logic signed [DW-1:0] prod;
        logic signed [DW-1:0] step;
        logic signed [SW-1:0] sum;
        logic signed [WW-1:0] nxt;
        trit_t                x;

        always_comb begin
            x = code_to_trit(held_codes[2*k +: 2]);
            if (x == 2'sd1) begin
                prod = DW'(err);
            end else if (x == -2'sd1) begin
                prod = -DW'(err);
            end else begin
                prod = '0;
            end
            step = prod >>> mu_sh;
            sum  = SW'(w[k]) + SW'(step);
            if (sum > SW'(WMAX)) begin
                nxt = WMAX;
            end else if (sum < SW'(WMIN)) begin
                nxt = WMIN;
            end else begin
                nxt = sum[WW-1:0];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                w[k] <= IDEAL;
            end else if (upd) begin
                w[k] <= nxt;
            end
        end
    end

endmodule

// File: rtl/lms_bg_cal.sv
module lms_bg_cal #(
    parameter int NSTG  = 6,
    parameter int WW    = 16,
    parameter int FRAC  = 6,
    parameter int DECIM = 32,
    parameter int MUW   = 5,
    localparam int AW   = WW + $clog2(NSTG) + 1,
    localparam int YW   = AW - FRAC
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 samp_vld,
    input  logic [2*NSTG-1:0]    stage_codes,
    input  logic                 ref_vld,
    input  logic signed [YW-1:0] ref_word,
    input  logic [MUW-1:0]       mu_sh,
    input  logic                 freeze,
    output logic                 y_vld,
    output logic signed [YW-1:0] y_out
);

    localparam int EW = AW + 1;

    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] held_acc;
    logic [2*NSTG-1:0]    held_codes;
    logic                 pend;
    logic                 upd;
    logic signed [EW-1:0] err;
    logic signed [WW-1:0] w [NSTG];
    logic [NSTG*WW-1:0]   w_flat;

    for (genvar k = 0; k < NSTG; k++) begin : g_flat
        assign w_flat[k*WW +: WW] = w[k];
    end

    lms_sum #(.NSTG(NSTG), .WW(WW), .AW(AW)) u_sum (
        .codes (stage_codes),
        .w     (w),
        .acc   (acc)
    );

    lms_tagger #(.NSTG(NSTG), .AW(AW), .DECIM(DECIM)) u_tag (
        .clk        (clk),
        .rst        (rst),
        .samp_vld   (samp_vld),
        .codes      (stage_codes),
        .acc        (acc),
        .ref_vld    (ref_vld),
        .held_codes (held_codes),
        .held_acc   (held_acc),
        .pend       (pend)
    );

    assign err = (EW'(ref_word) <<< FRAC) - EW'(held_acc);
    assign upd = ref_vld && pend && !freeze;

    lms_weights #(.NSTG(NSTG), .WW(WW), .FRAC(FRAC), .EW(EW), .MUW(MUW)) u_wt (
        .clk        (clk),
        .rst        (rst),
        .upd        (upd),
        .err        (err),
        .mu_sh      (mu_sh),
        .held_codes (held_codes),
        .w          (w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            y_vld <= 1'b0;
            y_out <= '0;
        end else begin
            y_vld <= samp_vld;
            if (samp_vld) begin
                y_out <= acc[AW-1:FRAC];
            end
        end
    end

endmodule

// File: rtl/lms_bg_cal_chk.sv
module lms_bg_cal_chk #(
    parameter int NSTG = 6,
    parameter int WW   = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               samp_vld,
    input logic               y_vld,
    input logic               ref_vld,
    input logic               freeze,
    input logic               pend,
    input logic [2*NSTG-1:0]  held_codes,
    input logic [NSTG*WW-1:0] w_flat
);

    assert_sample_to_out_R1: assert property (@(posedge clk) disable iff (rst)
        samp_vld |=> y_vld);

    assert_idle_no_out_R1: assert property (@(posedge clk) disable iff (rst)
        !samp_vld |=> !y_vld);

    assert_freeze_holds_R7: assert property (@(posedge clk) disable iff (rst)
        freeze |=> $stable(w_flat));

    assert_no_pending_no_update_R6: assert property (@(posedge clk) disable iff (rst)
        (!pend || !ref_vld) |=> $stable(w_flat));

    assert_zero_codes_no_update_R5: assert property (@(posedge clk) disable iff (rst)
        (ref_vld && pend && (held_codes == '0)) |=> $stable(w_flat));

endmodule

bind lms_bg_cal lms_bg_cal_chk #(.NSTG(NSTG), .WW(WW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .samp_vld   (samp_vld),
    .y_vld      (y_vld),
    .ref_vld    (ref_vld),
    .freeze     (freeze),
    .pend       (pend),
    .held_codes (held_codes),
    .w_flat     (w_flat)
);

// File: tb/tb_lms_bg_cal.sv
`timescale 1ns/1ps
module tb_lms_bg_cal;

    localparam int NSTG  = 6;
    localparam int WW    = 16;
    localparam int FRAC  = 6;
    localparam int DECIM = 32;
    localparam int YW    = 14;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 samp_vld = 1'b0;
    logic [2*NSTG-1:0]    stage_codes = '0;
    logic                 ref_vld = 1'b0;
    logic signed [YW-1:0] ref_word = '0;
    logic [4:0]           mu_sh = '0;
    logic                 freeze = 1'b0;
    logic                 y_vld;
    logic signed [YW-1:0] y_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench model state, built from the requirements
    int m_w [NSTG];
    int m_hc [NSTG];
    int m_hacc;
    int m_cnt;
    bit m_pend;
    int m_last_y;

    always #4 clk = ~clk;

    lms_bg_cal dut (
        .clk(clk), .rst(rst), .samp_vld(samp_vld), .stage_codes(stage_codes),
        .ref_vld(ref_vld), .ref_word(ref_word), .mu_sh(mu_sh), .freeze(freeze),
        .y_vld(y_vld), .y_out(y_out)
    );

    function automatic int trit(input logic [1:0] c);
        if (c == 2'b01) return 1;
        if (c == 2'b11) return -1;
        return 0;
    endfunction

    function automatic logic [2*NSTG-1:0] put(input logic [2*NSTG-1:0] v,
                                              input int k, input logic [1:0] c);
        logic [2*NSTG-1:0] r;
        r = v;
        r[2*k +: 2] = c;
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < NSTG; k++) begin
            m_w[k]  = 1 << (FRAC + NSTG - 1 - k);
            m_hc[k] = 0;
        end
        m_hacc = 0; m_cnt = 0; m_pend = 0; m_last_y = 0;
    endtask

    // one fast sample; checks the corrected word one cycle later
    task automatic send(input logic [2*NSTG-1:0] codes, input string req);
        int acc;
        int exp_y;
        acc = 0;
        for (int k = 0; k < NSTG; k++) acc += trit(codes[2*k +: 2]) * m_w[k];
        exp_y = acc >>> FRAC;
        if (m_cnt == 0) begin
            for (int k = 0; k < NSTG; k++) m_hc[k] = trit(codes[2*k +: 2]);
            m_hacc = acc;
            m_pend = 1;
        end
        m_cnt = (m_cnt + 1) % DECIM;
        @(negedge clk);
        samp_vld = 1'b1;
        stage_codes = codes;
        @(negedge clk);
        samp_vld = 1'b0;
        stage_codes = '0;
        check(y_vld == 1'b1, req, int'(y_vld), 1);
        check(int'(y_out) == exp_y, req, int'(y_out), exp_y);
        m_last_y = exp_y;
    endtask

    task automatic strobe(input int rv);
        if (m_pend) begin
            if (!freeze) begin
                int e;
                e = rv * (1 << FRAC) - m_hacc;
                for (int k = 0; k < NSTG; k++) begin
                    int s;
                    s = m_w[k] + ((e * m_hc[k]) >>> int'(mu_sh));
                    if (s > 32767) s = 32767;
                    if (s < -32768) s = -32768;
                    m_w[k] = s;
                end
            end
            m_pend = 0;
        end
        @(negedge clk);
        ref_vld = 1'b1;
        ref_word = YW'(rv);
        @(negedge clk);
        ref_vld = 1'b0;
    endtask

    task automatic fill_to_mark();
        while (m_cnt != 0) send('0, "R4 filler");
    endtask

    task automatic probe_all(input string req);
        for (int k = 0; k < NSTG; k++) send(put('0, k, 2'b01), req);
    endtask

    task automatic t_reset();
        check(y_vld == 1'b0, "R1 reset y_vld", int'(y_vld), 0);
        check(y_out == '0, "R1 reset y_out", int'(y_out), 0);
        strobe(100); // nothing held yet: R6
    endtask

    task automatic t_ideal();
        send({NSTG{2'b01}}, "R2 all plus");
        send({NSTG{2'b11}}, "R2 all minus");
        send(put(put(put('0, 0, 2'b01), 2, 2'b11), 5, 2'b01), "R2 mixed");
        send(put(put('0, 1, 2'b10), 3, 2'b01), "R3 reserved code is zero");
        send(put('0, 4, 2'b11), "R3 minus one stage 4");
        @(negedge clk);
        check(y_vld == 1'b0, "R1 idle y_vld", int'(y_vld), 0);
        check(int'(y_out) == m_last_y, "R1 idle y_out holds", int'(y_out), m_last_y);
    endtask

    task automatic t_adapt();
        mu_sh = 5'd3;
        fill_to_mark();
        send(put(put('0, 0, 2'b01), 2, 2'b11), "R5 marked sample");
        strobe(40);
        strobe(-300); // R6 second strobe ignored
        probe_all("R5/R6 weights after update");
    endtask

    task automatic t_decim();
        mu_sh = 5'd2;
        fill_to_mark();
        send(put('0, 1, 2'b01), "R4 marked A");
        send(put('0, 3, 2'b11), "R4 unmarked B");
        strobe(50);
        probe_all("R4 update used marked sample");
        fill_to_mark();
        send(put('0, 2, 2'b01), "R9 old marked");
        for (int i = 1; i < DECIM; i++) send(put('0, 5, 2'b01), "R9 unmarked run");
        send(put('0, 4, 2'b11), "R9 new marked");
        strobe(-20);
        probe_all("R9 newer sample used");
    endtask

    task automatic t_freeze();
        mu_sh = 5'd1;
        fill_to_mark();
        send(put('0, 0, 2'b01), "R7 marked");
        @(negedge clk) freeze = 1'b1;
        strobe(200);
        @(negedge clk) freeze = 1'b0;
        strobe(200); // consumed under freeze: no update
        probe_all("R7 weights unchanged");
    endtask

    task automatic t_sat();
        mu_sh = 5'd0;
        fill_to_mark();
        send(put('0, 0, 2'b01), "R8 marked high");
        strobe(8191);
        send(put('0, 0, 2'b01), "R8 probe high");
        check(m_last_y == 511, "R8 model high clamp", m_last_y, 511);
        fill_to_mark();
        send(put('0, 0, 2'b11), "R8 marked low");
        strobe(8191);
        send(put('0, 0, 2'b01), "R8 probe low");
        check(m_last_y == -512, "R8 model low clamp", m_last_y, -512);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ideal();
        t_adapt();
        t_decim();
        t_freeze();
        t_sat();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule